// File: doc/BRIEF.md
# Two-Identity Serial Bus Slave

This block is the slave front end of a two-wire serial bus (I2C style, 7-bit addressing). It watches SCL and SDA through oversampling flops clocked by the system clock. It finds start and stop conditions, shifts address and data bytes in and out, and drives the acknowledge bit. One set of pins carries two logical slaves. One is a memory device and the other is a companion register device, and each has its own 4-bit type code. Two strap pins select which of four same-type parts on the bus this one is.

Behind the bus side sits a byte-wide interface for the back-ends. A write strobe carries each received data byte. A read strobe takes the next byte to transmit. A device flag says which logical slave the access belongs to, and the back-ends decode that flag.

A supply-good input guards the bus. While the supply is low, the slave drops any transfer and lets go of SDA. It then stays deaf to the bus until the master sends a fresh start. Clock stretching and 10-bit addressing are not provided.

Top module: `tw_dual_slave`

## Requirements
- R1: An address byte with type bits [7:4] = 1010, bits [2:1] equal to `sel_i` and bit 0 = 0 is acknowledged. Data bytes that follow reach the back-end with `be_dev_o` = 0 (memory).
- R2: An address byte with type bits [7:4] = 1101 and matching select bits is acknowledged, and its accesses carry `be_dev_o` = 1 (companion).
- R3: An address byte with any other type code, or with bits [2:1] different from `sel_i`, is not acknowledged. SDA is left released, and no back-end strobe follows until the next start.
- R4: A start (SDA falling while SCL is high) aborts any transfer in progress, and the next 8 bits are taken as a new address byte.
- R5: A stop (SDA rising while SCL is high) ends the transfer. Bits clocked after a stop and before the next start are ignored: no acknowledge and no strobe.
- R6: In a write, each data byte is shifted in MSB first. It is presented on `be_wdata_o` with a one-cycle `be_wr_o` pulse and is acknowledged.
- R7: In a read (address bit 0 = 1), bytes from `be_rdata_i` are sent MSB first, with one `be_rd_o` pulse per byte. Sending goes on while the master acknowledges. A master NACK ends the read with no further `be_rd_o`.
- R8: While the synchronised supply-good is low, SDA is released and the transfer is dropped. Bits clocked after the supply returns are ignored until a new start.
- R9: `sda_oe_o` (1 = pull SDA low) is asserted only while the synchronised SCL is low. It is released after the acknowledge slot.
- R10: Out of reset, `sda_oe_o`, `be_wr_o` and `be_rd_o` are 0, and at most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| sel_i | input | 2 | Strap pins compared with address bits [2:1] |
| supply_ok_i | input | 1 | Supply above trip point |
| be_dev_o | output | 1 | Target of the access: 0 memory, 1 companion |
| be_wr_o | output | 1 | One-cycle strobe: data byte received |
| be_wdata_o | output | 8 | Received data byte, valid with `be_wr_o` |
| be_rd_o | output | 1 | One-cycle strobe: `be_rdata_i` is taken in this cycle |
| be_rdata_i | input | 8 | Byte to transmit, sampled when `be_rd_o` is high |

## Verification
Several properties are checked on every cycle:
- SDA is pulled low only while the sampled SCL is low.
- A stop returns the engine to idle with SDA released, and a start arms address reception.
- A low supply releases SDA on the next cycle.
- The transmit bit stays stable between SCL falls.
- The two strobes never overlap.

Whether each address is acknowledged, and which data reaches which device, can only be seen from the bench's transfers. The same holds for how many bytes a read delivers, and for the bus staying ignored after a stop or a supply drop until the next start.

// File: rtl/tw_pkg.sv
package tw_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK
    } tw_state_e;

    typedef struct packed {
        tw_state_e         state;
        logic [BYTE_W-1:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              ph;
        logic              addr_ph;
        logic              dev;
        logic              rw;
        logic              more;
        logic              oe;
    } tw_regs_t;
endpackage

// File: rtl/tw_sampler.sv
module tw_sampler #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic pwr_i,
    output logic scl_o,
    output logic sda_o,
    output logic pwr_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_d, scl_q, sda_d, sda_q, pwr_d, pwr_q;
    logic              scl_prev_d, scl_prev_q, sda_prev_d, sda_prev_q;

    always_comb begin
        scl_d      = {scl_q[STAGES-2:0], scl_i};
        sda_d      = {sda_q[STAGES-2:0], sda_i};
        pwr_d      = {pwr_q[STAGES-2:0], pwr_i};
        scl_prev_d = scl_q[STAGES-1];
        sda_prev_d = sda_q[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q      <= '1;
            sda_q      <= '1;
            pwr_q      <= '0;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_q      <= scl_d;
            sda_q      <= sda_d;
            pwr_q      <= pwr_d;
            scl_prev_q <= scl_prev_d;
            sda_prev_q <= sda_prev_d;
        end
    end

    assign scl_o      = scl_q[STAGES-1];
    assign sda_o      = sda_q[STAGES-1];
    assign pwr_o      = pwr_q[STAGES-1];
    assign scl_rise_o = scl_o & ~scl_prev_q;
    assign scl_fall_o = ~scl_o & scl_prev_q;
    assign start_o    = scl_o & scl_prev_q & sda_prev_q & ~sda_o;
    assign stop_o     = scl_o & scl_prev_q & ~sda_prev_q & sda_o;
endmodule

// File: rtl/tw_engine.sv
module tw_engine
    import tw_pkg::*;
#(
    parameter logic [3:0] MEM_ID = 4'b1010,
    parameter logic [3:0] CMP_ID = 4'b1101
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_s,
    input  logic              sda_s,
    input  logic              pwr_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_s,
    input  logic              stop_s,
    input  logic [1:0]        sel_i,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              oe_o,
    output logic              dev_o,
    output logic              wr_o,
    output logic              rd_o,
    output logic [BYTE_W-1:0] wdata_o
);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);

    tw_regs_t r_d, r_q;
    logic     wr, rd, id_mem, id_cmp, sel_ok;

    assign id_mem = (r_q.sh[7:4] == MEM_ID);
    assign id_cmp = (r_q.sh[7:4] == CMP_ID);
    assign sel_ok = (r_q.sh[2:1] == sel_i);

    always_comb begin
        r_d = r_q;
        wr  = 1'b0;
        rd  = 1'b0;
        if (!pwr_s) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else if (start_s) begin
            r_d.state   = ST_RX;
            r_d.addr_ph = 1'b1;
            r_d.cnt     = '0;
            r_d.oe      = 1'b0;
        end else if (stop_s) begin
            r_d.state = ST_IDLE;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                ST_RX: if (scl_rise) begin
                    r_d.sh  = {r_q.sh[BYTE_W-2:0], sda_s};
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.state = ST_ACK;
                        r_d.ph    = 1'b0;
                    end
                end
                ST_ACK: if (scl_fall) begin
                    if (!r_q.ph) begin
                        r_d.ph = 1'b1;
                        if (r_q.addr_ph) begin
                            if ((id_mem || id_cmp) && sel_ok) begin
                                r_d.oe      = 1'b1;
                                r_d.dev     = id_cmp;
                                r_d.rw      = r_q.sh[0];
                                r_d.addr_ph = 1'b0;
                            end else begin
                                r_d.state = ST_IDLE;
                            end
                        end else begin
                            wr     = 1'b1;
                            r_d.oe = 1'b1;
                        end
                    end else if (r_q.rw) begin
                        rd        = 1'b1;
                        r_d.sh    = rdata_i;
                        r_d.oe    = ~rdata_i[BYTE_W-1];
                        r_d.cnt   = '0;
                        r_d.state = ST_TX;
                    end else begin
                        r_d.oe    = 1'b0;
                        r_d.cnt   = '0;
                        r_d.state = ST_RX;
                    end
                end
                ST_TX: if (scl_fall) begin
                    r_d.cnt = r_q.cnt + 1'b1;
                    if (r_q.cnt == LAST_BIT) begin
                        r_d.oe    = 1'b0;
                        r_d.state = ST_MACK;
                    end else begin
                        r_d.sh = {r_q.sh[BYTE_W-2:0], 1'b0};
                        r_d.oe = ~r_q.sh[BYTE_W-2];
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        r_d.more = ~sda_s;
                    end else if (scl_fall) begin
                        if (r_q.more) begin
                            rd        = 1'b1;
                            r_d.sh    = rdata_i;
                            r_d.oe    = ~rdata_i[BYTE_W-1];
                            r_d.cnt   = '0;
                            r_d.state = ST_TX;
                        end else begin
                            r_d.state = ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: ST_IDLE, sh: '0, cnt: '0, ph: 1'b0, addr_ph: 1'b0,
                     dev: 1'b0, rw: 1'b0, more: 1'b0, oe: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign oe_o    = r_q.oe;
    assign dev_o   = r_q.dev;
    assign wr_o    = wr;
    assign rd_o    = rd;
    assign wdata_o = r_q.sh;

    a_r9_drive_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.oe) |-> !scl_s);
    a_r8_supply_release: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> (!r_q.oe && r_q.state == ST_IDLE));
    a_r5_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_s && pwr_s) |=> (r_q.state == ST_IDLE && !r_q.oe));
    a_r4_start_arms_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (start_s && pwr_s) |=> (r_q.state == ST_RX && r_q.addr_ph && r_q.cnt == '0));
    a_r7_tx_bit_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == ST_TX && !scl_fall && !start_s && !stop_s && pwr_s) |=> $stable(r_q.oe));
    a_r10_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr, rd}));
endmodule

// File: rtl/tw_dual_slave.sv
module tw_dual_slave
    import tw_pkg::*;
#(
    parameter logic [3:0] MEM_ID      = 4'b1010,
    parameter logic [3:0] CMP_ID      = 4'b1101,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [1:0]        sel_i,
    input  logic              supply_ok_i,
    output logic              be_dev_o,
    output logic              be_wr_o,
    output logic [BYTE_W-1:0] be_wdata_o,
    output logic              be_rd_o,
    input  logic [BYTE_W-1:0] be_rdata_i
);
    logic scl_s, sda_s, pwr_s, scl_rise, scl_fall, start_s, stop_s;

    tw_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .pwr_i     (supply_ok_i),
        .scl_o     (scl_s),
        .sda_o     (sda_s),
        .pwr_o     (pwr_s),
        .scl_rise_o(scl_rise),
        .scl_fall_o(scl_fall),
        .start_o   (start_s),
        .stop_o    (stop_s)
    );

    tw_engine #(.MEM_ID(MEM_ID), .CMP_ID(CMP_ID)) u_engine (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_s   (scl_s),
        .sda_s   (sda_s),
        .pwr_s   (pwr_s),
        .scl_rise(scl_rise),
        .scl_fall(scl_fall),
        .start_s (start_s),
        .stop_s  (stop_s),
        .sel_i   (sel_i),
        .rdata_i (be_rdata_i),
        .oe_o    (sda_oe_o),
        .dev_o   (be_dev_o),
        .wr_o    (be_wr_o),
        .rd_o    (be_rd_o),
        .wdata_o (be_wdata_o)
    );
endmodule

// File: tb/tw_dual_slave_tb.sv
module tw_dual_slave_tb;
    localparam int CLK_PERIOD = 10;
    localparam int Q          = 6;
    localparam logic [1:0] SEL = 2'b10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1, supply = 1'b1;
    logic       sda_oe, be_dev, be_wr, be_rd;
    logic [7:0] be_wdata, be_rdata;
    logic       sda_bus;
    int         rd_cnt = 0;
    int         checks = 0, failures = 0, oe_bad = 0;
    int         wr_n = 0;
    logic [7:0] wlog_data [0:255];
    logic       wlog_dev  [0:255];
    int         exp_idx = 0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus  = sda_m & ~sda_oe;
    assign be_rdata = be_dev ? (8'hC0 ^ 8'(rd_cnt)) : (8'h50 + 8'(rd_cnt));

    tw_dual_slave u_dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(sda_oe),
        .sel_i(SEL), .supply_ok_i(supply), .be_dev_o(be_dev), .be_wr_o(be_wr),
        .be_wdata_o(be_wdata), .be_rd_o(be_rd), .be_rdata_i(be_rdata)
    );

    always @(posedge clk) if (be_rd) rd_cnt <= rd_cnt + 1;

    logic oe_prev = 1'b0;
    always @(negedge clk) begin
        if (be_wr && wr_n < 256) begin
            wlog_data[wr_n] = be_wdata;
            wlog_dev[wr_n]  = be_dev;
            wr_n = wr_n + 1;
        end
        if (sda_oe && !oe_prev && scl_m) oe_bad = oe_bad + 1;
        oe_prev = sda_oe;
    end

    function automatic logic [7:0] exp_rd(input logic dev, input int idx);
        return dev ? (8'hC0 ^ 8'(idx)) : (8'h50 + 8'(idx));
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            failures = failures + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic m_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask
    task automatic m_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask
    task automatic m_wbit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask
    task automatic m_rbit(output logic b);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b = sda_bus; wq(); scl_m = 1'b0; wq();
    endtask
    task automatic m_wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) m_wbit(d[i]);
        m_rbit(b);
        ack = ~b;
    endtask
    task automatic m_rbyte(input logic give_ack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin m_rbit(b); d[i] = b; end
        m_wbit(~give_ack);
    endtask

    function automatic logic [7:0] addr(input logic [3:0] id, input logic [1:0] s, input logic rw);
        return {id, 1'b0, s, rw};
    endfunction

    logic done = 1'b0;
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures = failures + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic       ack;
        logic [7:0] d;
        logic       b;
        int         w0;
        void'($urandom(32'h5EED_0042));
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && be_wr == 1'b0 && be_rd == 1'b0, "R10 reset", {sda_oe, be_wr, be_rd}, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);

        // R1 / R6: memory write, two bytes
        w0 = wr_n;
        m_start(); m_wbyte(addr(4'b1010, SEL, 1'b0), ack);
        chk(ack, "R1 mem addr ack", ack, 1);
        m_wbyte(8'hA5, ack); chk(ack, "R6 data ack", ack, 1);
        m_wbyte(8'h3C, ack); chk(ack, "R6 data ack", ack, 1);
        m_stop();
        chk(wr_n == w0 + 2, "R6 write count", wr_n - w0, 2);
        chk(wlog_data[w0] == 8'hA5 && wlog_data[w0+1] == 8'h3C, "R6 write data",
            {wlog_data[w0], wlog_data[w0+1]}, 16'hA53C);
        chk(wlog_dev[w0] == 1'b0, "R1 mem dev", wlog_dev[w0], 0);

        // R2: companion write
        w0 = wr_n;
        m_start(); m_wbyte(addr(4'b1101, SEL, 1'b0), ack);
        chk(ack, "R2 comp addr ack", ack, 1);
        m_wbyte(8'h81, ack); m_stop();
        chk(wr_n == w0 + 1 && wlog_dev[w0] == 1'b1 && wlog_data[w0] == 8'h81, "R2 comp write",
            wlog_data[w0], 8'h81);

        // R3: wrong select and wrong type
        w0 = wr_n;
        m_start(); m_wbyte(addr(4'b1010, ~SEL, 1'b0), ack);
        chk(!ack, "R3 sel mismatch nack", ack, 0);
        m_wbyte(8'h11, ack); chk(!ack, "R3 no ack after nack", ack, 0); m_stop();
        m_start(); m_wbyte(addr(4'b1011, SEL, 1'b0), ack);
        chk(!ack, "R3 type mismatch nack", ack, 0);
        m_wbyte(8'h22, ack); m_stop();
        chk(wr_n == w0, "R3 no strobe", wr_n - w0, 0);

        // R4: repeated start mid-byte
        w0 = wr_n;
        m_start(); m_wbyte(addr(4'b1010, SEL, 1'b0), ack);
        for (int i = 0; i < 4; i++) m_wbit(1'b1);
        m_start(); m_wbyte(addr(4'b1101, SEL, 1'b0), ack);
        chk(ack, "R4 readdress ack", ack, 1);
        m_wbyte(8'h5A, ack); m_stop();
        chk(wr_n == w0 + 1 && wlog_dev[w0] == 1'b1 && wlog_data[w0] == 8'h5A, "R4 abort+new",
            wr_n - w0, 1);

        // R5: bits after stop ignored
        w0 = wr_n;
        m_wbyte(addr(4'b1010, SEL, 1'b0), ack);
        chk(!ack, "R5 ignored after stop", ack, 0);
        m_wbyte(8'h77, ack);
        chk(wr_n == w0, "R5 no strobe after stop", wr_n - w0, 0);
        m_stop();

        // R7: three-byte read from memory
        exp_idx = rd_cnt;
        m_start(); m_wbyte(addr(4'b1010, SEL, 1'b1), ack);
        chk(ack, "R7 read addr ack", ack, 1);
        for (int k = 0; k < 3; k++) begin
            m_rbyte(k != 2, d);
            chk(d == exp_rd(1'b0, exp_idx), "R7 read byte", d, exp_rd(1'b0, exp_idx));
            exp_idx = exp_idx + 1;
        end
        m_stop();
        repeat (20) @(negedge clk);
        chk(rd_cnt == exp_idx, "R7 no read after nack", rd_cnt, exp_idx);
        chk(sda_oe == 1'b0, "R9 released after read", sda_oe, 0);

        // R8: supply drop mid-byte
        w0 = wr_n;
        m_start(); m_wbyte(addr(4'b1010, SEL, 1'b0), ack);
        for (int i = 0; i < 4; i++) m_wbit(1'b0);
        supply = 1'b0; repeat (10) @(negedge clk);
        chk(sda_oe == 1'b0, "R8 released on low supply", sda_oe, 0);
        supply = 1'b1; repeat (10) @(negedge clk);
        for (int i = 0; i < 4; i++) m_wbit(1'b1);
        m_rbit(b);
        chk(b == 1'b1, "R8 no ack after drop", b, 1);
        m_wbyte(8'h99, ack);
        chk(wr_n == w0, "R8 no strobe after drop", wr_n - w0, 0);
        m_stop();
        m_start(); m_wbyte(addr(4'b1010, SEL, 1'b0), ack);
        chk(ack, "R8 start after supply return", ack, 1);
        m_stop();

        // random transfers
        for (int t = 0; t < 24; t++) begin
            int         u = $urandom % 4;
            logic [3:0] id = (u < 2) ? 4'b1010 : (u == 2) ? 4'b1101 : 4'b0110;
            logic [1:0] s  = (($urandom % 4) == 0) ? (SEL ^ 2'b01) : SEL;
            logic       rw = 1'($urandom % 2);
            int         nb = 1 + $urandom % 3;
            logic       match = (id != 4'b0110) && (s == SEL);
            logic       dv = (id == 4'b1101);
            w0 = wr_n;
            exp_idx = rd_cnt;
            m_start(); m_wbyte(addr(id, s, rw), ack);
            chk(ack == match, match ? (dv ? "R2 rand ack" : "R1 rand ack") : "R3 rand nack", ack, match);
            if (match && rw) begin
                for (int k = 0; k < nb; k++) begin
                    m_rbyte(k != nb - 1, d);
                    chk(d == exp_rd(dv, exp_idx), "R7 rand read", d, exp_rd(dv, exp_idx));
                    exp_idx = exp_idx + 1;
                end
            end else if (match) begin
                for (int k = 0; k < nb; k++) begin
                    logic [7:0] v = 8'($urandom);
                    m_wbyte(v, ack);
                    chk(ack && wr_n == w0 + k + 1 && wlog_data[w0+k] == v && wlog_dev[w0+k] == dv,
                        "R6 rand write", wlog_data[w0+k], v);
                end
            end
            m_stop();
            repeat (10) @(negedge clk);
            if (!match) chk(wr_n == w0 && rd_cnt == exp_idx, "R3 rand no strobe", wr_n - w0, 0);
        end

        chk(oe_bad == 0, "R9 drive only with scl low", oe_bad, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule